// File: doc/BRIEF.md
# Continuous-Read Result Streamer

This block is the streaming side of a serial converter port. A host first sends one command byte that selects the result register with the continuous-read bit set. From then on, each new conversion result is shifted out on the serial output as the host toggles the serial clock. No command byte is needed before each word. The ready flag goes low when a word is loaded and goes high again once the last bit has been read. Each word can be read only once. If a word has not been fully read when the next conversion completes, the new word replaces it.

While it streams, the block keeps sampling the serial input. A command byte with the exit pattern returns the port to waiting for a normal command. That byte is counted in 8-bit steps from the start of each result frame, and it only takes effect while a word is pending. A long run of ones on the serial input resets the port at any time. The serial pins are oversampled by the system clock: the clock, select and data inputs each pass through a synchronizer, and their edges are detected in the system clock domain.

Top module: `cr_result_streamer`

## Requirements
- R1: After reset, `word_ready_n` is 1, `ser_out` is 1 and the port waits for a command byte.
- R2: Command bits are taken MSB first on `ser_clk` rising edges. A byte whose top six bits are 001111 switches to streaming. A byte with any other top bits (for example 001101xx) leaves the port waiting for a command.
- R3: While the port waits for a command, a 1 arriving as the first bit of a byte is dropped. The byte starts at the first 0.
- R4: A `conv_done` strobe loads `conv_word`, drives `word_ready_n` low and holds `ser_out` low until the first bit is shifted.
- R5: In streaming mode with `word_ready_n` low, each `ser_clk` falling edge puts the next result bit on `ser_out`, MSB first, with no command byte.
- R6: On the rising edge that follows the last (RES_W-th) falling edge, `word_ready_n` goes to 1 and `ser_out` shows 1.
- R7: Once a word has been read, further `ser_clk` pulses before the next conversion give `ser_out` = 1 and never repeat the word.
- R8: A `conv_done` during a partial read discards the rest of the old word. The next falling edge gives the new word's MSB.
- R9: In streaming mode, a byte whose top six bits are 001110, completed on an 8-bit boundary counted from the last load and while `word_ready_n` is low, returns the port to waiting for a command. After that, results are not shifted out and `ser_out` follows the ready flag.
- R10: An exit byte sent while `word_ready_n` is 1 is ignored, and the next word streams normally.
- R11: ONES_RUN (default 32) consecutive 1s sampled on `ser_in` reset the port: `word_ready_n` goes to 1 and the port waits for a command.
- R12: While `sel_n` is 1, `ser_clk` edges are ignored. No bit is shifted out, no `ser_in` bit is sampled and no bit counts toward the ones run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host, idles high |
| sel_n | input | 1 | Active-low port select |
| ser_in | input | 1 | Serial data from the host |
| conv_done | input | 1 | One-cycle strobe: a new result is available |
| conv_word | input | RES_W | Result word captured on `conv_done` |
| ser_out | output | 1 | Result bit, or the ready level when no bit is shifting |
| word_ready_n | output | 1 | Low while an unread result is pending |

## Verification
The hardest case to reach is the exit command while data is flowing. The exit byte must end exactly on a frame-aligned 8-bit boundary while the ready flag is still low. In that same window the falling edges are shifting the first result bits out. The stimulus produces this by loading a word and then sending the exit byte as the first eight clocks of the frame. The bench checks that those eight clocks return the word's upper byte, and that a later conversion produces no shifted data. A conversion is also made to land partway through a read, to check that the frame restarts.

// File: rtl/cr_stream_pkg.sv
package cr_stream_pkg;

    localparam int CMD_BITS = 8;

    typedef enum logic {
        ST_CMD    = 1'b0,
        ST_STREAM = 1'b1
    } cr_state_e;

    // top six bits select: write-enable 0, fixed 0, result register, read, continuous flag
    localparam logic [5:0] ENTER_TOP = 6'b001111;
    localparam logic [5:0] LEAVE_TOP = 6'b001110;

    function automatic logic is_enter(input logic [CMD_BITS-1:0] b);
        return b[CMD_BITS-1 -: 6] == ENTER_TOP;
    endfunction

    function automatic logic is_leave(input logic [CMD_BITS-1:0] b);
        return b[CMD_BITS-1 -: 6] == LEAVE_TOP;
    endfunction

endpackage

// File: rtl/cr_sync.sv
module cr_sync #(
    parameter int                 WIDTH  = 3,
    parameter int                 STAGES = 2,
    parameter logic [WIDTH-1:0]   IDLE   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_comb begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_regs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= IDLE;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cr_ones_watch.sv
module cr_ones_watch #(
    parameter int RUN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic bit_i,
    output logic hit_o
);
    localparam int CW = $clog2(RUN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        hit_o = sample_i && bit_i && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (sample_i) begin
            if (!bit_i || hit_o) cnt_d = '0;
            else                 cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11: a completed run starts the next run from zero
    p_run_restarts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (cnt_q == '0));

    // R12: the run counter only moves on a sampled bit
    p_run_needs_sample_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(cnt_q));

endmodule

// File: rtl/cr_cmd_window.sv
module cr_cmd_window
    import cr_stream_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                sample_i,
    input  logic                bit_i,
    input  logic                hold_lead_i,
    output logic [CMD_BITS-1:0] byte_o,
    output logic                done_o
);
    localparam int CW = $clog2(CMD_BITS);
    localparam logic [CW-1:0] LAST = CW'(CMD_BITS - 1);

    typedef struct packed {
        logic [CMD_BITS-1:0] win;
        logic [CW-1:0]       cnt;
    } win_t;

    win_t d, q;
    logic skip, take;

    always_comb begin
        skip   = hold_lead_i && (q.cnt == '0) && bit_i;
        take   = sample_i && !skip;
        byte_o = {q.win[CMD_BITS-2:0], bit_i};
        done_o = take && (q.cnt == LAST);
        d = q;
        if (clr_i) begin
            d.win = '0;
            d.cnt = '0;
        end else if (take) begin
            d.win = byte_o;
            d.cnt = done_o ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: every completed byte leaves the window aligned for the next one
    p_wrap_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (q.cnt == '0));

    // R3: a dropped leading one does not advance the bit position
    p_lead_one_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && skip && !clr_i) |=> $stable(q.cnt));

endmodule

// File: rtl/cr_result_streamer.sv
module cr_result_streamer
    import cr_stream_pkg::*;
#(
    parameter int RES_W       = 16,
    parameter int ONES_RUN    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             sel_n,
    input  logic             ser_in,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_word,
    output logic             ser_out,
    output logic             word_ready_n
);
    localparam int CNT_W = $clog2(RES_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(RES_W);

    typedef struct packed {
        cr_state_e        st;
        logic [RES_W-1:0] sh;
        logic [CNT_W-1:0] rd_cnt;
        logic             rdy_n;
        logic             act;
        logic             obit;
        logic             sclk_prev;
    } strm_t;

    strm_t d, q;

    logic [2:0]          pins_s;
    logic                sclk_s, sel_s, din_s;
    logic                rise, fall;
    logic                win_clr, byte_done, ones_hit;
    logic [CMD_BITS-1:0] win_byte;

    // pin order {data, select, clock}; idle is clock high, deselected
    cr_sync #(
        .WIDTH (3),
        .STAGES(SYNC_STAGES),
        .IDLE  (3'b011)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({ser_in, sel_n, ser_clk}),
        .sync_o (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign sel_s  = pins_s[1];
    assign din_s  = pins_s[2];
    assign rise   = !sel_s && sclk_s && !q.sclk_prev;
    assign fall   = !sel_s && !sclk_s && q.sclk_prev;

    cr_cmd_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (win_clr),
        .sample_i   (rise),
        .bit_i      (din_s),
        .hold_lead_i(q.st == ST_CMD),
        .byte_o     (win_byte),
        .done_o     (byte_done)
    );

    cr_ones_watch #(
        .RUN(ONES_RUN)
    ) u_ones (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_i(rise),
        .bit_i   (din_s),
        .hit_o   (ones_hit)
    );

    always_comb begin
        d           = q;
        d.sclk_prev = sclk_s;
        win_clr     = 1'b0;
        if (ones_hit) begin
            d.st     = ST_CMD;
            d.sh     = '0;
            d.rd_cnt = '0;
            d.rdy_n  = 1'b1;
            d.act    = 1'b0;
            d.obit   = 1'b1;
            win_clr  = 1'b1;
        end else if (conv_done) begin
            d.sh     = conv_word;
            d.rd_cnt = '0;
            d.rdy_n  = 1'b0;
            d.act    = 1'b0;
            win_clr  = (q.st == ST_STREAM);
        end else begin
            unique case (q.st)
                ST_CMD: begin
                    if (byte_done && is_enter(win_byte)) begin
                        d.st     = ST_STREAM;
                        d.rd_cnt = '0;
                        d.act    = 1'b0;
                        win_clr  = 1'b1;
                    end
                end
                ST_STREAM: begin
                    if (fall && !q.rdy_n && (q.rd_cnt < FULL)) begin
                        d.obit   = q.sh[RES_W-1];
                        d.sh     = {q.sh[RES_W-2:0], 1'b0};
                        d.rd_cnt = q.rd_cnt + 1'b1;
                        d.act    = 1'b1;
                    end
                    if (rise && !q.rdy_n && (q.rd_cnt == FULL)) begin
                        d.rdy_n = 1'b1;
                        d.act   = 1'b0;
                    end
                    if (byte_done && is_leave(win_byte) && !q.rdy_n) begin
                        d.st    = ST_CMD;
                        d.act   = 1'b0;
                        win_clr = 1'b1;
                    end
                end
                default: d.st = ST_CMD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_CMD;
            q.sh        <= '0;
            q.rd_cnt    <= '0;
            q.rdy_n     <= 1'b1;
            q.act       <= 1'b0;
            q.obit      <= 1'b1;
            q.sclk_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ser_out      = q.act ? q.obit : q.rdy_n;
    assign word_ready_n = q.rdy_n;

    // R4: a load drops the ready flag and the output line shows it
    p_load_drops_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !ones_hit) |=> (!word_ready_n && !ser_out));

    // R7: with no word pending the shift register stays put
    p_read_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STREAM && q.rdy_n && !conv_done && !ones_hit) |=> $stable(q.sh));

    // R6: the bit counter never runs past one word
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_cnt <= FULL);

    // R2: leaving the command wait needs a completed byte from the window
    p_entry_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CMD && !byte_done) |=> (q.st == ST_CMD));

    // R10: the exit byte has no effect while no word is pending
    p_exit_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STREAM && q.rdy_n && !ones_hit) |=> (q.st == ST_STREAM));

    // R11: the ones run forces the idle interface state
    p_ones_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ones_hit |=> (word_ready_n && ser_out && q.st == ST_CMD));

endmodule

// File: tb/tb_cr_result_streamer.sv
module tb_cr_result_streamer;
    localparam int CLK_P = 10;
    localparam int HALF  = 8 * CLK_P;
    localparam int RES_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ser_clk = 1'b1;
    logic             sel_n = 1'b0;
    logic             ser_in = 1'b0;
    logic             conv_done = 1'b0;
    logic [RES_W-1:0] conv_word = '0;
    logic             ser_out, word_ready_n;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    cr_result_streamer #(.RES_W(RES_W)) dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n),
        .ser_in(ser_in), .conv_done(conv_done), .conv_word(conv_word),
        .ser_out(ser_out), .word_ready_n(word_ready_n)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one serial clock: fall, hold low, sample output, rise
    task automatic sbit(input logic d, output logic o);
        ser_in  = d;
        ser_clk = 1'b0;
        #(HALF);
        o = ser_out;
        ser_clk = 1'b1;
        #(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) sbit(b[i], got[i]);
        ser_in = 1'b0;
    endtask

    task automatic read_word(input logic d, output logic [RES_W-1:0] got);
        for (int i = RES_W - 1; i >= 0; i--) sbit(d, got[i]);
        ser_in = 1'b0;
    endtask

    task automatic convert(input logic [RES_W-1:0] w);
        @(negedge clk);
        conv_word = w;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 ready", word_ready_n, 1);
        check("R1 out", ser_out, 1);
    endtask

    task automatic t_no_entry();
        logic [7:0] g8; logic [RES_W-1:0] w;
        send_byte(8'h34, g8);
        convert(16'hFFFF);
        read_word(1'b0, w);
        check("R2 non-entry byte stays idle", w, 16'h0000);
    endtask

    task automatic t_entry_and_read();
        logic o; logic [7:0] g8; logic [RES_W-1:0] w;
        for (int i = 0; i < 3; i++) sbit(1'b1, o);
        send_byte(8'h3C, g8);
        convert(16'hA5C3);
        check("R4 ready low", word_ready_n, 0);
        check("R4 out low", ser_out, 0);
        read_word(1'b0, w);
        check("R3 R5 streamed word", w, 16'hA5C3);
        check("R6 ready high after last bit", word_ready_n, 1);
        check("R6 out high", ser_out, 1);
    endtask

    task automatic t_read_once();
        logic [RES_W-1:0] w;
        read_word(1'b0, w);
        check("R7 no repeat", w, 16'hFFFF);
    endtask

    task automatic t_discard();
        logic o; logic [4:0] p; logic [RES_W-1:0] w;
        convert(16'h1234);
        for (int i = 4; i >= 0; i--) begin sbit(1'b0, o); p[i] = o; end
        check("R8 partial bits", p, 5'b00010);
        convert(16'hBEEF);
        read_word(1'b0, w);
        check("R8 new word replaces old", w, 16'hBEEF);
    endtask

    task automatic t_deselect();
        logic o; logic [RES_W-1:0] w; int moved;
        convert(16'h7E81);
        sel_n = 1'b1;
        #(HALF);
        moved = 0;
        for (int i = 0; i < 40; i++) begin sbit(1'b1, o); if (o !== 1'b0) moved++; end
        ser_in = 1'b0;
        check("R12 output quiet while deselected", moved, 0);
        check("R12 ones run ignored", word_ready_n, 0);
        sel_n = 1'b0;
        #(HALF);
        read_word(1'b0, w);
        check("R12 word intact", w, 16'h7E81);
    endtask

    task automatic t_exit_ignored();
        logic [7:0] g8; logic [RES_W-1:0] w;
        send_byte(8'h38, g8);
        check("R7 R10 out high during ignored exit", g8, 8'hFF);
        convert(16'h0F0F);
        read_word(1'b0, w);
        check("R10 still streaming", w, 16'h0F0F);
    endtask

    task automatic t_exit();
        logic [7:0] g8; logic [RES_W-1:0] w;
        convert(16'h5A5A);
        send_byte(8'h38, g8);
        check("R9 bits during exit byte", g8, 8'h5A);
        convert(16'hFFFF);
        read_word(1'b0, w);
        check("R9 no data after exit", w, 16'h0000);
    endtask

    task automatic t_ones_reset();
        logic o; logic [7:0] g8; logic [RES_W-1:0] w;
        send_byte(8'h3C, g8);
        convert(16'h9999);
        for (int i = 0; i < 32; i++) sbit(1'b1, o);
        ser_in = 1'b0;
        #(HALF);
        check("R11 ready high", word_ready_n, 1);
        check("R11 out high", ser_out, 1);
        convert(16'hFFFF);
        read_word(1'b0, w);
        check("R11 back to command wait", w, 16'h0000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_no_entry();
        t_entry_and_read();
        t_read_once();
        t_discard();
        t_deselect();
        t_exit_ignored();
        t_exit();
        t_ones_reset();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule